// File: doc/BRIEF.md
# Horizontal Panel Drive Timing Generator

This block produces the horizontal-side control waveforms for a line-scanned active-matrix display whose horizontal shift register can run in either direction. Each line-start strobe starts one line window. In that window the block emits a precharge start pulse, then a horizontal start pulse a fixed number of clock stages later, and a pair of complementary two-phase shift clocks. It also drives a direction level that tells the panel which way to shift.

The block runs from one system clock at an integer multiple of the shift-clock rate. Every edge position is a whole count of system clocks. A scan-direction request is sampled with a frame strobe. It reaches the panel only while no line is in progress, so a line is never scanned in mixed directions. In left scan, the start pulses are inverted and the clock phase is swapped, which keeps the active area centred.

Top module: `hscan_pulse_gen`

## Requirements
- R1: After reset, `pst` and `hst` are 0, `hck1` is 0, `hck2` is 1, `rgt` is 1 (right scan), and no line window is open.
- R2: `hck2` is the complement of `hck1` on every cycle.
- R3: A line window opens on the cycle after `line_go` is sampled high while idle. Within the window each shift-clock period is `DIV` system clocks long. In right scan `hck1` is 1 for the first `DIV/2` cycles of each period and 0 for the rest. Outside a window `hck1` is 0.
- R4: The precharge start pulse is active for the first `DIV/2` cycles of period 0 of the window. Its leading edge coincides with the clock edge that opens that period, and it is inactive at all other times.
- R5: The horizontal start pulse is active for the first `DIV/2` cycles of period `LEAD`, so it leads by `LEAD` shift-clock periods after the precharge pulse. It is inactive at all other times.
- R6: The window lasts `LEAD+STAGES` shift-clock periods. After that the outputs return to the idle state without another strobe.
- R7: When `rgt` is 0 (left scan), the start pulses are active low and idle high. During a window `hck1` is 0 for the first `DIV/2` cycles of each period and 1 for the rest. The idle `hck1`/`hck2` levels stay as in R1.
- R8: `dir_right` is captured only on a cycle where `frame_go` is 1. The captured value reaches `rgt` on the first cycle with no line window open, so `rgt` never changes inside a window. Changes to `dir_right` without `frame_go` have no effect.
- R9: A `line_go` strobe that arrives while a window is open is ignored. It neither restarts nor extends the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `DIV` times the shift-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_go | input | 1 | Line-start strobe |
| frame_go | input | 1 | Frame-boundary strobe; captures `dir_right` |
| dir_right | input | 1 | Requested scan direction, 1 = right, 0 = left |
| pst | output | 1 | Precharge start pulse |
| hst | output | 1 | Horizontal start pulse |
| hck1 | output | 1 | Shift clock, phase 1 |
| hck2 | output | 1 | Shift clock, phase 2 |
| rgt | output | 1 | Applied scan direction, 1 = right |

## Verification
The bench builds the block with `DIV=4`, `STAGES=6` and `LEAD=2`, so a whole line window is 32 system clocks. With that size, the first start pulse, the lead gap, the last clock period and the return to idle can all be sampled in one short line, in both directions. The short window also makes a mid-line direction request and a mid-line restart strobe cheap to place, and it keeps visible both the moment the captured direction is finally applied and the absence of any restart.

// File: rtl/hscan_pulse_gen.sv
module hscan_pulse_gen #(
  parameter int DIV    = 4,
  parameter int STAGES = 228,
  parameter int LEAD   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_go,
  input  logic frame_go,
  input  logic dir_right,
  output logic pst,
  output logic hst,
  output logic hck1,
  output logic hck2,
  output logic rgt
);
  localparam int HALF  = DIV / 2;
  localparam int TOTAL = LEAD + STAGES;
  localparam int PW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW    = $clog2(TOTAL + 1);

  logic          busy;
  logic [PW-1:0] ph;
  logic [CW-1:0] per;
  logic          rgt_q, pend, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ph    <= '0;
      per   <= '0;
      rgt_q <= 1'b1;
      pend  <= 1'b0;
      nxt   <= 1'b1;
    end else begin
      if (busy) begin
        if (ph == PW'(DIV - 1)) begin
          ph <= '0;
          if (per == CW'(TOTAL - 1)) begin
            busy <= 1'b0;
            per  <= '0;
          end else begin
            per <= per + 1'b1;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end else if (line_go) begin
        busy <= 1'b1;
        ph   <= '0;
        per  <= '0;
      end
      if (frame_go) begin
        pend <= 1'b1;
        nxt  <= dir_right;
      end else if (pend && !busy) begin
        pend  <= 1'b0;
        rgt_q <= nxt;
      end
    end
  end

  wire first_half = ph < PW'(HALF);
  wire act_p      = busy && (per == '0) && first_half;
  wire act_h      = busy && (per == CW'(LEAD)) && first_half;

  assign hck1 = busy & ~(first_half ^ rgt_q);
  assign hck2 = ~hck1;
  assign pst  = act_p ^ ~rgt_q;
  assign hst  = act_h ^ ~rgt_q;
  assign rgt  = rgt_q;
endmodule

// File: rtl/hscan_pulse_gen_chk.sv
module hscan_pulse_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic pst,
  input logic hst,
  input logic hck1,
  input logic hck2,
  input logic rgt
);
  a_r2_complement: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hck1) |-> $fell(hck2));
  a_r3_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!hck1 && hck2));
  a_r4_pst_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rgt && $rose(pst)) |-> $rose(hck1));
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !((pst == rgt) && (hst == rgt)));
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pst == ~rgt && hst == ~rgt));
  a_r8_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rgt));
endmodule

bind hscan_pulse_gen hscan_pulse_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pst(pst), .hst(hst),
  .hck1(hck1), .hck2(hck2), .rgt(rgt)
);

// File: tb/hscan_pulse_gen_tb_top.sv
module hscan_pulse_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, line_go = 1'b0, frame_go = 1'b0, dir_right = 1'b1;
  logic pst, hst, hck1, hck2, rgt;
  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hscan_pulse_gen #(.DIV(4), .STAGES(6), .LEAD(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_go(line_go), .frame_go(frame_go),
    .dir_right(dir_right), .pst(pst), .hst(hst), .hck1(hck1), .hck2(hck2), .rgt(rgt)
  );

  // k[9:4] offset, [3] idle, [2] pst, [1] hst, [0] hck1 (right-scan values)
  localparam logic [9:0] VEC [0:11] = '{
    {6'd0,  4'b0101}, {6'd1,  4'b0101}, {6'd2,  4'b0000}, {6'd4,  4'b0001},
    {6'd7,  4'b0000}, {6'd8,  4'b0011}, {6'd9,  4'b0011}, {6'd10, 4'b0000},
    {6'd12, 4'b0001}, {6'd31, 4'b0000}, {6'd32, 4'b1000}, {6'd33, 4'b1000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic start_line;
    line_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    line_go = 1'b0;
    cyc = 0;
  endtask

  task automatic step_to(input int k);
    while (cyc < k) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic walk(input bit right);
    start_line();
    for (int i = 0; i < 12; i++) begin
      logic [2:0] e;
      step_to(int'(VEC[i][9:4]));
      if (VEC[i][3]) e = right ? 3'b000 : 3'b110;
      else e = right ? VEC[i][2:0] : ~VEC[i][2:0];
      chk(right ? "R3/R4/R5/R6 right" : "R7 left", {5'b0, pst, hst, hck1}, {5'b0, e});
      chk("R2", {7'b0, hck2}, {7'b0, ~hck1});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {3'b0, pst, hst, hck1, hck2, rgt}, 8'b00000011);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {3'b0, pst, hst, hck1, hck2, rgt}, 8'b00000011);

    walk(1'b1);

    // R9: strobe mid-line is ignored
    start_line();
    step_to(5);
    line_go = 1'b1;
    step_to(6);
    line_go = 1'b0;
    chk("R9 no restart pst", {7'b0, pst}, 8'd0);
    step_to(8);
    chk("R9 hst keeps schedule", {7'b0, hst}, 8'd1);
    step_to(32);
    chk("R9/R6 window not extended", {6'b0, hck1, pst}, 8'd0);
    step_to(40);

    // R8: direction request mid-line waits until idle
    start_line();
    step_to(3);
    dir_right = 1'b0;
    frame_go = 1'b1;
    step_to(4);
    frame_go = 1'b0;
    step_to(8);
    chk("R8 hst still right-scan", {7'b0, hst}, 8'd1);
    step_to(10);
    chk("R8 rgt frozen in window", {7'b0, rgt}, 8'd1);
    step_to(34);
    chk("R8 rgt applied at idle", {7'b0, rgt}, 8'd0);
    dir_right = 1'b1;
    step_to(40);
    chk("R8 no frame strobe no effect", {7'b0, rgt}, 8'd0);

    walk(1'b0);

    step_to(40);
    frame_go = 1'b1;
    step_to(41);
    frame_go = 1'b0;
    step_to(43);
    chk("R8 back to right", {6'b0, rgt, pst}, 8'b10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule